// File: doc/BRIEF.md
# Flash Page Program Sequencer

This block writes one 128-byte page into a flash array model. Programming follows a fixed, timed control sequence. A start request carries the page base address, and that address must be page aligned. When the start is accepted, the write-enable strobe rises and a settling count runs down. After that, a load window opens. During the window, bytes are written into an internal page buffer by their offset. The buffer is preset to all ones at every accepted start, so any offset that is never written programs as 0xFF. A commit request ends the load window and starts the first program loop.

Each loop runs four phases, and each phase lasts a cycle count taken from an input:

1. Program setup.
2. Program pulse. Its length is read from a per-loop table.
3. Pulse release, with setup still held.
4. Setup release, with only write-enable held.

After the four phases, the block raises a verify request. An external pass/fail answer then does one of three things:

- A pass ends the operation with done.
- A fail starts another loop.
- A fail after the last allowed loop ends the operation with an error.

A guard timer is re-armed at the start of every loop. If a loop runs longer than the guard limit, the guard aborts it.

The array model supports a whole-page program write and a combinational byte read port. Programming can only clear bits.

Top module: `flash_page_prog`

## Requirements
- R1: A start request in idle whose address has a nonzero offset field (bits [6:0]) is refused. The block stays idle with every strobe low, and error_o is high from the next cycle.
- R2: An accepted start raises swe_o. load_rdy_o rises after exactly t_wen_i cycles of swe_o alone. A byte write made while load_rdy_o is low has no effect.
- R3: Every accepted start presets all 128 buffer bytes to 0xFF. The page that is programmed is selected by address bits [ADDR_W-1:7]. Offsets left unwritten program as 0xFF.
- R4: After commit, psu_o is high alone for exactly t_setup_i cycles before pgm_o rises. pgm_o is never high without psu_o and swe_o.
- R5: Loop k drives pgm_o for the number of cycles held in pulse_tbl_i[k*CNT_W +: CNT_W], where k counts up from 0. A table entry of 0 acts as 1.
- R6: When the pulse ends, psu_o stays high for t_rel_i cycles. Then psu_o drops and swe_o is held alone for t_srel_i cycles. Then verify_req_o rises.
- R7: A verify answer with pass set ends the operation: done_o goes high, busy_o goes low, and every strobe goes low. An answer with pass clear increments loop_o and restarts the setup phase.
- R8: A failed answer in loop MAX_LOOPS-1 ends the operation with error_o high. loop_o never reaches MAX_LOOPS.
- R9: The guard counts the cycles of setup, pulse and both release phases from the start of each loop. If that count reaches wdt_limit_i, the block returns to idle with error_o set and all strobes low. A pulse cut short in this way leaves the array unchanged. A loop lasting exactly wdt_limit_i cycles completes.
- R10: After reset the array reads 0xFF everywhere. Each completed pulse ANDs the page buffer into the selected page.
- R11: A start request while busy_o is high is ignored.
- R12: An accepted start clears done_o and error_o. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request |
| start_addr_i | input | ADDR_W | Page base address |
| wr_en_i | input | 1 | Buffer byte write strobe |
| wr_off_i | input | 7 | Byte offset within page |
| wr_data_i | input | 8 | Byte data |
| commit_i | input | 1 | End of load, begin programming |
| verify_valid_i | input | 1 | Verify answer strobe |
| verify_pass_i | input | 1 | Verify answer, 1 = pass |
| t_wen_i | input | CNT_W | Write-enable settle cycles |
| t_setup_i | input | CNT_W | Program setup cycles |
| t_rel_i | input | CNT_W | Pulse release cycles |
| t_srel_i | input | CNT_W | Setup release cycles |
| wdt_limit_i | input | CNT_W | Guard limit per loop, in cycles |
| pulse_tbl_i | input | MAX_LOOPS*CNT_W | Pulse length per loop index |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Last operation passed |
| error_o | output | 1 | Last operation failed or was refused |
| load_rdy_o | output | 1 | Load window open |
| swe_o | output | 1 | Write-enable strobe |
| psu_o | output | 1 | Program setup strobe |
| pgm_o | output | 1 | Program pulse strobe |
| verify_req_o | output | 1 | Waiting for verify answer |
| loop_o | output | LOOP_W | Current loop index |

## Verification
The bench walks four page programs that differ in page, in fill length (full page, a few bytes, half page, one byte) and in the number of failed verifies before a pass. Together they separate padding from written data, and they show whether each loop reads its own pulse table entry rather than the first one. Directed cases then cover the remaining behaviour:

- A misaligned start.
- A rewrite of a page, which shows AND programming.
- Writes and starts issued outside the windows that accept them.
- Running out of loops.
- A zero pulse entry.
- A guard limit that cuts a pulse short, set against a limit equal to the loop length, which tells an off-by-one guard from a correct one.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  localparam int PAGE_BYTES = 128;
  localparam int OFF_W      = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WEN,
    ST_LOAD,
    ST_SETUP,
    ST_PULSE,
    ST_PREL,
    ST_SREL,
    ST_VERIFY
  } seq_state_e;
endpackage

// File: rtl/flash_page_buf.sv
module flash_page_buf #(
  parameter int PAGE_BYTES = 128,
  parameter int OFF_W      = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    preset_i,
  input  logic                    we_i,
  input  logic [OFF_W-1:0]        off_i,
  input  logic [7:0]              data_i,
  output logic [PAGE_BYTES*8-1:0] page_o
);
  logic [PAGE_BYTES*8-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       page_q <= '1;
    else if (preset_i) page_q <= '1;
    else if (we_i)     page_q[off_i*8 +: 8] <= data_i;
  end

  assign page_o = page_q;
endmodule

// File: rtl/flash_phase_cnt.sv
module flash_phase_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   nxt;

  assign nxt    = {1'b0, cnt_q} + 1'b1;
  // limit 0 behaves as 1
  assign done_o = nxt >= {1'b0, lim_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (!done_o) cnt_q <= nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/flash_array_model.sv
module flash_array_model #(
  parameter int NUM_PAGES  = 4,
  parameter int PAGE_BYTES = 128,
  parameter int OFF_W      = 7,
  parameter int PG_W       = 2,
  parameter int ADDR_W     = OFF_W + PG_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    prog_i,
  input  logic [PG_W-1:0]         page_idx_i,
  input  logic [PAGE_BYTES*8-1:0] page_data_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [7:0]              rd_data_o
);
  logic [7:0] mem_q [NUM_PAGES][PAGE_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PAGES; p++)
        for (int b = 0; b < PAGE_BYTES; b++)
          mem_q[p][b] <= 8'hFF;
    end else if (prog_i) begin
      // cells only go 1 -> 0
      for (int b = 0; b < PAGE_BYTES; b++)
        mem_q[page_idx_i][b] <= mem_q[page_idx_i][b] & page_data_i[b*8 +: 8];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i[ADDR_W-1:OFF_W]][rd_addr_i[OFF_W-1:0]];

  AST_ARRAY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_i |=> ($stable(rd_addr_i) -> $stable(rd_data_o))); // R10
endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog
  import flash_prog_pkg::*;
#(
  parameter int NUM_PAGES  = 4,
  parameter int MAX_LOOPS  = 4,
  parameter int CNT_W      = 16,
  localparam int PG_W      = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int ADDR_W    = OFF_W + PG_W,
  localparam int LOOP_W    = (MAX_LOOPS > 1) ? $clog2(MAX_LOOPS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [ADDR_W-1:0]          start_addr_i,
  input  logic                       wr_en_i,
  input  logic [OFF_W-1:0]           wr_off_i,
  input  logic [7:0]                 wr_data_i,
  input  logic                       commit_i,
  input  logic                       verify_valid_i,
  input  logic                       verify_pass_i,
  input  logic [CNT_W-1:0]           t_wen_i,
  input  logic [CNT_W-1:0]           t_setup_i,
  input  logic [CNT_W-1:0]           t_rel_i,
  input  logic [CNT_W-1:0]           t_srel_i,
  input  logic [CNT_W-1:0]           wdt_limit_i,
  input  logic [MAX_LOOPS*CNT_W-1:0] pulse_tbl_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [7:0]                 rd_data_o,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       error_o,
  output logic                       load_rdy_o,
  output logic                       swe_o,
  output logic                       psu_o,
  output logic                       pgm_o,
  output logic                       verify_req_o,
  output logic [LOOP_W-1:0]          loop_o
);
  seq_state_e state_q, state_d;
  logic [LOOP_W-1:0]       loop_q;
  logic [PG_W-1:0]         page_q;
  logic [CNT_W-1:0]        guard_q, lim;
  logic                    done_q, err_q;
  logic                    accept, set_done, set_err, loop_inc, guard_clr, prog;
  logic                    ph_done, armed, abort;
  logic [PAGE_BYTES*8-1:0] page_data;

  assign armed = (state_q == ST_SETUP) || (state_q == ST_PULSE) ||
                 (state_q == ST_PREL)  || (state_q == ST_SREL);
  assign abort = armed && (guard_q >= wdt_limit_i);

  always_comb begin
    unique case (state_q)
      ST_WEN:   lim = t_wen_i;
      ST_SETUP: lim = t_setup_i;
      ST_PULSE: lim = pulse_tbl_i[int'(loop_q)*CNT_W +: CNT_W];
      ST_PREL:  lim = t_rel_i;
      ST_SREL:  lim = t_srel_i;
      default:  lim = '0;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    accept    = 1'b0;
    set_done  = 1'b0;
    set_err   = 1'b0;
    loop_inc  = 1'b0;
    guard_clr = 1'b0;
    prog      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (start_addr_i[OFF_W-1:0] == '0) begin
          accept  = 1'b1;
          state_d = ST_WEN;
        end else set_err = 1'b1;
      end
      ST_WEN:  if (ph_done) state_d = ST_LOAD;
      ST_LOAD: if (commit_i) begin
        state_d   = ST_SETUP;
        guard_clr = 1'b1;
      end
      ST_SETUP: if (ph_done) state_d = ST_PULSE;
      ST_PULSE: if (ph_done) begin
        state_d = ST_PREL;
        prog    = 1'b1;
      end
      ST_PREL: if (ph_done) state_d = ST_SREL;
      ST_SREL: if (ph_done) state_d = ST_VERIFY;
      ST_VERIFY: if (verify_valid_i) begin
        if (verify_pass_i) begin
          set_done = 1'b1;
          state_d  = ST_IDLE;
        end else if (int'(loop_q) == MAX_LOOPS - 1) begin
          set_err = 1'b1;
          state_d = ST_IDLE;
        end else begin
          loop_inc  = 1'b1;
          guard_clr = 1'b1;
          state_d   = ST_SETUP;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort) begin
      state_d = ST_IDLE;
      set_err = 1'b1;
      prog    = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      loop_q  <= '0;
      page_q  <= '0;
      guard_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        loop_q <= '0;
        page_q <= start_addr_i[ADDR_W-1:OFF_W];
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end else begin
        if (loop_inc) loop_q <= loop_q + 1'b1;
        if (set_done) done_q <= 1'b1;
        if (set_err) begin
          err_q  <= 1'b1;
          done_q <= 1'b0;
        end
      end
      if (guard_clr)  guard_q <= '0;
      else if (armed) guard_q <= guard_q + 1'b1;
    end
  end

  flash_phase_cnt #(.CNT_W(CNT_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_d != state_q),
    .lim_i  (lim),
    .done_o (ph_done)
  );

  flash_page_buf #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .preset_i (accept),
    .we_i     (wr_en_i && (state_q == ST_LOAD)),
    .off_i    (wr_off_i),
    .data_i   (wr_data_i),
    .page_o   (page_data)
  );

  flash_array_model #(
    .NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W),
    .PG_W(PG_W), .ADDR_W(ADDR_W)
  ) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .prog_i      (prog),
    .page_idx_i  (page_q),
    .page_data_i (page_data),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o)
  );

  assign busy_o       = state_q != ST_IDLE;
  assign load_rdy_o   = state_q == ST_LOAD;
  assign swe_o        = busy_o;
  assign psu_o        = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_PREL);
  assign pgm_o        = state_q == ST_PULSE;
  assign verify_req_o = state_q == ST_VERIFY;
  assign done_o       = done_q;
  assign error_o      = err_q;
  assign loop_o       = loop_q;

  AST_MISALIGN_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && start_addr_i[OFF_W-1:0] != '0) |=> (!busy_o && error_o)); // R1
  AST_PGM_UNDER_PSU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_o |-> (psu_o && swe_o)); // R4
  AST_PSU_LEADS_PGM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pgm_o) |-> $past(psu_o)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(swe_o || psu_o || pgm_o || load_rdy_o || verify_req_o)); // R7
  AST_LOOP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(loop_o) < MAX_LOOPS); // R8
  AST_ABORT_IDLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> (!busy_o && error_o)); // R9
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_rdy_o && start_i && !commit_i) |=> load_rdy_o); // R11
  AST_STATUS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o)); // R12
endmodule

// File: tb/tb_flash_page_prog.sv
`timescale 1ns/1ps
module tb_flash_page_prog;
  localparam int NUM_PAGES = 4;
  localparam int MAX_LOOPS = 4;
  localparam int CNT_W     = 16;
  localparam int ADDR_W    = 9;
  localparam int OFF_W     = 7;
  localparam int LOOP_W    = 2;
  localparam int PB        = 128;
  localparam int T_WEN = 4, T_SETUP = 3, T_REL = 2, T_SREL = 2;

  localparam int NV = 4;
  localparam logic [ADDR_W-1:0] V_ADDR [NV] = '{9'h000, 9'h080, 9'h100, 9'h180};
  localparam int                V_LEN  [NV] = '{128, 5, 64, 1};
  localparam logic [7:0]        V_SEED [NV] = '{8'h11, 8'h40, 8'h23, 8'h05};
  localparam int                V_FAIL [NV] = '{0, 1, 2, 0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic wr_en_i = 1'b0;
  logic [OFF_W-1:0] wr_off_i = '0;
  logic [7:0] wr_data_i = '0;
  logic commit_i = 1'b0, verify_valid_i = 1'b0, verify_pass_i = 1'b0;
  logic [CNT_W-1:0] wdt_limit = 16'd40;
  logic [MAX_LOOPS*CNT_W-1:0] pulse_tbl;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic busy_o, done_o, error_o, load_rdy_o, swe_o, psu_o, pgm_o, verify_req_o;
  logic [LOOP_W-1:0] loop_o;

  int tbl [MAX_LOOPS] = '{6, 3, 8, 4};
  logic [7:0] shadow [NUM_PAGES*PB];
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  always_comb
    for (int k = 0; k < MAX_LOOPS; k++) pulse_tbl[k*CNT_W +: CNT_W] = CNT_W'(tbl[k]);

  flash_page_prog #(.NUM_PAGES(NUM_PAGES), .MAX_LOOPS(MAX_LOOPS), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .start_addr_i(start_addr_i),
    .wr_en_i(wr_en_i), .wr_off_i(wr_off_i), .wr_data_i(wr_data_i), .commit_i(commit_i),
    .verify_valid_i(verify_valid_i), .verify_pass_i(verify_pass_i),
    .t_wen_i(CNT_W'(T_WEN)), .t_setup_i(CNT_W'(T_SETUP)), .t_rel_i(CNT_W'(T_REL)),
    .t_srel_i(CNT_W'(T_SREL)), .wdt_limit_i(wdt_limit), .pulse_tbl_i(pulse_tbl),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .busy_o(busy_o), .done_o(done_o),
    .error_o(error_o), .load_rdy_o(load_rdy_o), .swe_o(swe_o), .psu_o(psu_o),
    .pgm_o(pgm_o), .verify_req_o(verify_req_o), .loop_o(loop_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic read_chk(input logic [ADDR_W-1:0] a, input string req);
    rd_addr_i = a;
    #1;
    check(req, int'(rd_data_o), int'(shadow[a]));
  endtask

  task automatic run_prog(input logic [ADDR_W-1:0] addr, input int n, input logic [7:0] seed,
                          input int fails, input bit disturb, input bit exp_abort);
    int wc, su, cp, sr, pw, pulses, left, guard, ew;
    bit in_pulse, after_pulse;
    wc = 0; su = 0; cp = 0; sr = 0; pw = 0; pulses = 0; left = fails; guard = 0;
    in_pulse = 0; after_pulse = 0;
    @(negedge clk);
    start_i = 1'b1; start_addr_i = addr;
    @(negedge clk);
    start_i = 1'b0;
    check("R12 status cleared", int'({done_o, error_o}), 0);
    while (!load_rdy_o && guard < 1000) begin
      if (swe_o) wc++;
      if (disturb && wc == 1) begin
        wr_en_i = 1'b1; wr_off_i = 7'd5; wr_data_i = 8'h00;
      end else wr_en_i = 1'b0;
      @(negedge clk); guard++;
    end
    wr_en_i = 1'b0;
    check("R2 write-enable settle cycles", wc, T_WEN);
    if (disturb) begin
      start_i = 1'b1; start_addr_i = 9'h100;
      @(negedge clk);
      start_i = 1'b0;
      check("R11 start ignored while busy", int'(load_rdy_o), 1);
    end
    for (int i = 0; i < n; i++) begin
      wr_en_i = 1'b1; wr_off_i = OFF_W'(i); wr_data_i = seed + 8'(i);
      @(negedge clk);
    end
    wr_en_i = 1'b0; commit_i = 1'b1;
    @(negedge clk);
    commit_i = 1'b0;
    guard = 0;
    while (busy_o && guard < 3000) begin
      verify_valid_i = 1'b0;
      if (pgm_o) begin
        if (!in_pulse) begin
          in_pulse = 1; pw = 0;
          check("R4 setup lead cycles", su, T_SETUP);
        end
        pw++;
      end else begin
        if (in_pulse) begin
          in_pulse = 0; after_pulse = 1;
          ew = (tbl[pulses] == 0) ? 1 : tbl[pulses];
          check("R5 pulse width for loop", pw, ew);
          pulses++;
        end
        if (psu_o) begin
          if (after_pulse) cp++; else su++;
        end else if (swe_o && !verify_req_o && after_pulse) sr++;
        if (verify_req_o) begin
          check("R6 pulse release cycles", cp, T_REL);
          check("R6 setup release cycles", sr, T_SREL);
          check("R7 loop index", int'(loop_o), pulses - 1);
          verify_valid_i = 1'b1;
          verify_pass_i  = (left == 0);
          if (left > 0) left--;
          su = 0; cp = 0; sr = 0; after_pulse = 0;
        end
      end
      @(negedge clk); guard++;
    end
    verify_valid_i = 1'b0;
    check("R7 strobes low at end", int'({busy_o, swe_o, psu_o, pgm_o}), 0);
    if (exp_abort) begin
      check("R9 abort error", int'({done_o, error_o}), 1);
      check("R9 no pulse completed", pulses, 0);
    end else if (fails >= MAX_LOOPS) begin
      check("R8 loops exhausted error", int'({done_o, error_o}), 1);
      check("R8 pulse count", pulses, MAX_LOOPS);
    end else begin
      check("R7 done after pass", int'({done_o, error_o}), 2);
      check("R7 pulse count", pulses, fails + 1);
    end
    if (!exp_abort)
      for (int i = 0; i < PB; i++)
        shadow[int'(addr) + i] &= (i < n) ? (seed + 8'(i)) : 8'hFF;
    read_chk(addr, "R3 first byte");
    read_chk(addr + ADDR_W'(n - 1), "R3 last written byte");
    if (n < PB) read_chk(addr + ADDR_W'(n), "R3 padded byte");
    read_chk(addr + 9'd5, "R10 byte 5");
    read_chk(addr + 9'd127, "R3 page end");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM_PAGES*PB; i++) shadow[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R7 reset idle", int'({busy_o, done_o, error_o, swe_o, psu_o, pgm_o}), 0);
    read_chk(9'h0C3, "R10 reset array ones");

    for (int v = 0; v < NV; v++)
      run_prog(V_ADDR[v], V_LEN[v], V_SEED[v], V_FAIL[v], 1'b0, 1'b0);

    // misaligned start
    @(negedge clk);
    start_i = 1'b1; start_addr_i = 9'h045;
    @(negedge clk);
    start_i = 1'b0;
    check("R1 misaligned error", int'(error_o), 1);
    check("R1 misaligned idle", int'({busy_o, swe_o}), 0);

    // rewrite ANDs, stray write and start ignored
    run_prog(9'h080, 3, 8'h0F, 0, 1'b1, 1'b0);
    rd_addr_i = 9'h080; #1;
    check("R10 and programming", int'(rd_data_o), 8'h00);
    read_chk(9'h146, "R11 other page untouched");

    // loops exhausted
    run_prog(9'h000, 2, 8'h30, 4, 1'b0, 1'b0);

    // zero pulse entry
    tbl[0] = 0;
    run_prog(9'h100, 1, 8'h7F, 0, 1'b0, 1'b0);
    tbl[0] = 6;

    // guard cuts the pulse
    wdt_limit = 16'd5;
    run_prog(9'h180, 1, 8'h00, 0, 1'b0, 1'b1);
    rd_addr_i = 9'h180; #1;
    check("R9 aborted page unchanged", int'(rd_data_o), 8'h05);

    // guard equal to loop length completes
    wdt_limit = 16'd13;
    run_prog(9'h180, 1, 8'h01, 0, 1'b0, 1'b0);
    check("R9 exact limit completes", int'(done_o), 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule